// File: doc/BRIEF.md
# Compiler-Scheduled Instruction Issue Gate

This block sits in front of an instruction issue stage. It reads a stream of 64-bit words in which one scheduling control word is followed by the three instructions it governs, and that pattern repeats. The control word is never issued. It is split into three per-instruction slots. Each slot tells the gate how many cycles to hold the next instruction after this one issues, whether to raise a yield hint, which dependency barriers this instruction arms when it issues, and which barriers must be clear before it may issue. Long-latency units pulse release strobes to clear barriers. The compiler therefore owns dependence timing and the gate does no register-level dependence checking.

The stream uses a valid/ready pair. A control word is consumed as soon as it is valid. An instruction word is consumed in the same cycle the gate raises issue enable, and the word appears on the issue output in that cycle.

Top module: `sched_issue_gate`

## Requirements
- R1: While reset is asserted and right after it, issue_en and yield_hint are 0, no barrier is pending, and the first word accepted is treated as a control word (word_ready is 1 in that phase).
- R2: A control word is accepted with word_ready=1 and issue_en=0. The next three accepted words are instructions. The first uses slot bits [20:0], the second uses [41:21] and the third uses [62:42]. The word accepted after the third instruction is again a control word.
- R3: Within a 21-bit slot, bits [3:0] are the stall count, bit [4] is the yield flag, bits [7:5] are the write-barrier index, bits [10:8] are the read-barrier index, and bits [16:11] are the wait mask (bit 11+i names barrier i).
- R4: If an instruction issues in cycle t with stall count s, the next instruction cannot issue before cycle t+1+s. If it is valid and not blocked by a barrier, it issues in exactly that cycle.
- R5: An instruction whose wait mask names a pending barrier does not issue. Once a release strobe for the last named pending barrier is sampled at a clock edge, it may issue in the following cycle.
- R6: A write-barrier or read-barrier index from 0 to 5 marks that barrier pending from the cycle after the instruction issues. Index values 6 and 7 arm nothing.
- R7: bar_release[i] sampled at an edge clears barrier i. If the same edge also arms barrier i, the barrier stays pending.
- R8: yield_hint is 1 for exactly the one cycle after an instruction with its yield flag set issues, and is 0 at every other time.
- R9: In an instruction phase, word_ready equals issue_en, and while issue_en is 1 issue_word equals word_data.
- R10: Control-word bit 63 and each slot's bits [20:17] have no effect on issue timing, barriers or yield.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Stream word present |
| word_data | input | 64 | Stream word (control or instruction) |
| word_ready | output | 1 | Stream word consumed this cycle |
| bar_release | input | 6 | Per-barrier release strobes |
| issue_en | output | 1 | Instruction on issue_word issues this cycle |
| issue_word | output | 64 | Instruction eligible to issue |
| yield_hint | output | 1 | One-cycle yield indication after a yielding issue |

## Verification
The bench builds the gate with its default widths: three slots per control word, six barriers and a 4-bit stall count. With these widths a stall of 15 cycles, a wait mask naming all six barriers, and the out-of-range indices 6 and 7 are all reachable from random control words. The directed groups fix the exact issue cycles under a stall, a write-barrier wait, a read-barrier wait and a mask covering every barrier. The random groups, with a valid signal that sometimes drops and random release strobes, also cover a barrier that is armed and released at the same edge.

// File: rtl/sched_gate_pkg.sv
package sched_gate_pkg;
    localparam int WORD_W    = 64;
    localparam int GROUP     = 3;
    localparam int STALL_W   = 4;
    localparam int NUM_BAR   = 6;
    localparam int BAR_IDX_W = 3;
    localparam int RSV_W     = 4;
    localparam int CTL_W     = STALL_W + 1 + 2 * BAR_IDX_W + NUM_BAR;
    localparam int FIELD_W   = CTL_W + RSV_W;
    localparam int SLOT_W    = $clog2(GROUP + 1);

    typedef struct packed {
        logic [NUM_BAR-1:0]   wait_mask;
        logic [BAR_IDX_W-1:0] rd_bar;
        logic [BAR_IDX_W-1:0] wr_bar;
        logic                 yield;
        logic [STALL_W-1:0]   stall;
    } slot_ctl_t;

    function automatic logic [NUM_BAR-1:0] bar_onehot(input logic [BAR_IDX_W-1:0] idx);
        logic [NUM_BAR-1:0] oh;
        oh = '0;
        for (int b = 0; b < NUM_BAR; b++) begin
            if (idx == BAR_IDX_W'(b)) oh[b] = 1'b1;
        end
        return oh;
    endfunction
endpackage

// File: rtl/sgate_ctl_decode.sv
module sgate_ctl_decode
    import sched_gate_pkg::*;
(
    input  logic [WORD_W-1:0]           ctl_word,
    output slot_ctl_t [GROUP-1:0]       slots
);
    for (genvar g = 0; g < GROUP; g++) begin : g_slot
        assign slots[g] = ctl_word[g*FIELD_W +: CTL_W];
    end
endmodule

// File: rtl/sgate_stall_timer.sv
module sgate_stall_timer
    import sched_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [STALL_W-1:0] load_val,
    output logic               busy
);
    logic [STALL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/sgate_barrier_board.sv
module sgate_barrier_board
    import sched_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BAR-1:0] arm,
    input  logic [NUM_BAR-1:0] release_in,
    input  logic [NUM_BAR-1:0] wait_mask,
    output logic               blocked,
    output logic [NUM_BAR-1:0] pend
);
    logic [NUM_BAR-1:0] pend_d, pend_q;

    for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
        always_comb begin
            pend_d[b] = arm[b] | (pend_q[b] & ~release_in[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign blocked = |(wait_mask & pend_q);
    assign pend    = pend_q;
endmodule

// File: rtl/sched_issue_gate.sv
module sched_issue_gate
    import sched_gate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [63:0]         word_data,
    output logic                word_ready,
    input  logic [5:0]          bar_release,
    output logic                issue_en,
    output logic [63:0]         issue_word,
    output logic                yield_hint
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP);

    typedef struct packed {
        logic [SLOT_W-1:0]    slot;
        slot_ctl_t [GROUP-1:0] ctl;
        logic                 yield;
    } gate_state_t;

    gate_state_t st_d, st_q;

    slot_ctl_t [GROUP-1:0] dec_slots;
    slot_ctl_t             cur_ctl;
    logic                  in_ctrl;
    logic                  stall_busy;
    logic                  bar_blocked;
    logic [NUM_BAR-1:0]    pend_q;
    logic [NUM_BAR-1:0]    arm_mask;

    sgate_ctl_decode u_dec (
        .ctl_word (word_data),
        .slots    (dec_slots)
    );

    always_comb begin
        cur_ctl = '0;
        for (int g = 0; g < GROUP; g++) begin
            if (st_q.slot == SLOT_W'(g + 1)) cur_ctl = st_q.ctl[g];
        end
    end

    assign in_ctrl  = (st_q.slot == '0);
    assign issue_en = word_valid && !in_ctrl && !stall_busy && !bar_blocked;
    assign arm_mask = issue_en ? (bar_onehot(cur_ctl.wr_bar) | bar_onehot(cur_ctl.rd_bar))
                               : '0;

    sgate_stall_timer u_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue_en),
        .load_val (cur_ctl.stall),
        .busy     (stall_busy)
    );

    sgate_barrier_board u_bar (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm_mask),
        .release_in (bar_release),
        .wait_mask  (cur_ctl.wait_mask),
        .blocked    (bar_blocked),
        .pend       (pend_q)
    );

    always_comb begin
        st_d       = st_q;
        st_d.yield = issue_en & cur_ctl.yield;
        if (word_valid && in_ctrl) begin
            st_d.ctl  = dec_slots;
            st_d.slot = SLOT_W'(1);
        end else if (issue_en) begin
            st_d.slot = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_ready = in_ctrl | issue_en;
    assign issue_word = in_ctrl ? '0 : word_data;
    assign yield_hint = st_q.yield;
endmodule

// File: rtl/sgate_checker.sv
module sgate_checker
    import sched_gate_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               issue_en,
    input logic               word_ready,
    input logic               yield_hint,
    input logic               in_ctrl,
    input logic               stall_busy,
    input slot_ctl_t          cur_ctl,
    input logic [NUM_BAR-1:0] pend_q,
    input logic [NUM_BAR-1:0] bar_release
);
    logic [NUM_BAR-1:0] wr_oh;
    assign wr_oh = bar_onehot(cur_ctl.wr_bar);

    assert_ctrl_no_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ctrl |-> !issue_en);

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_busy |-> !issue_en);

    assert_stall_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && cur_ctl.stall != '0) |=> !issue_en);

    assert_wait_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> ((cur_ctl.wait_mask & pend_q) == '0));

    assert_arm_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |=> ((pend_q & $past(wr_oh)) == $past(wr_oh)));

    assert_release_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_en && bar_release != '0) |=> ((pend_q & $past(bar_release)) == '0));

    assert_yield_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && cur_ctl.yield) |=> yield_hint);

    assert_yield_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_en && cur_ctl.yield) |=> !yield_hint);

    assert_ready_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ctrl |-> (word_ready == issue_en));
endmodule

bind sched_issue_gate sgate_checker u_sgate_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_en    (issue_en),
    .word_ready  (word_ready),
    .yield_hint  (yield_hint),
    .in_ctrl     (in_ctrl),
    .stall_busy  (stall_busy),
    .cur_ctl     (cur_ctl),
    .pend_q      (pend_q),
    .bar_release (bar_release)
);

// File: tb/test_sched_issue_gate.sv
module test_sched_issue_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_valid;
    logic [63:0] word_data;
    logic        word_ready;
    logic [5:0]  bar_release;
    logic        issue_en;
    logic [63:0] issue_word;
    logic        yield_hint;

    always #10 clk = ~clk;

    sched_issue_gate i_sched_issue_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .word_ready  (word_ready),
        .bar_release (bar_release),
        .issue_en    (issue_en),
        .issue_word  (issue_word),
        .yield_hint  (yield_hint)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] wq [0:511];
    int wn = 0;
    int rp = 0;
    int cyc = 0;
    int iss_t [0:15];
    int n_iss = 0;

    int          m_slot;
    logic [63:0] m_ctl;
    int          m_stall;
    logic [5:0]  m_pend;
    bit          m_yield;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [20:0] mkf(input int stall, input bit y, input int wr, input int rd,
                                        input logic [5:0] wmask, input logic [3:0] rsv);
        return {rsv, wmask, 3'(rd), 3'(wr), y, 4'(stall)};
    endfunction

    function automatic logic [5:0] onehot6(input logic [2:0] idx);
        return (idx < 3'd6) ? (6'd1 << idx) : 6'd0;
    endfunction

    task automatic step(input bit dir, input bit rnd);
        logic [20:0] f;
        bit          e_issue;
        bit          e_ready;
        bit          acc;
        string       tag;
        @(negedge clk);
        #1;
        word_valid = (rp < wn) && (!rnd || ($urandom % 4) != 0);
        word_data  = (rp < wn) ? wq[rp] : 64'd0;
        bar_release = '0;
        if (dir) begin
            if (n_iss == 1 && cyc == iss_t[0] + 8) bar_release = 6'b000100;
            if (n_iss == 5 && cyc == iss_t[4] + 4) bar_release = 6'b001000;
        end else if (rnd) begin
            for (int b = 0; b < 6; b++) bar_release[b] = (($urandom % 6) == 0);
        end
        #4;
        f = (m_slot == 0) ? 21'd0 : m_ctl[21*(m_slot-1) +: 21];
        e_issue = word_valid && m_slot != 0 && m_stall == 0 && ((f[16:11] & m_pend) == 6'd0);
        e_ready = (m_slot == 0) || e_issue;
        if (m_slot == 0)                          tag = "R2";
        else if (m_stall != 0)                    tag = "R4";
        else if ((f[16:11] & m_pend) != 6'd0)     tag = "R5 R7";
        else                                      tag = "R9";
        chk(issue_en == e_issue, {tag, " issue_en"}, 64'(issue_en), 64'(e_issue));
        chk(word_ready == e_ready, "R9 word_ready", 64'(word_ready), 64'(e_ready));
        chk(yield_hint == m_yield, "R8 yield_hint", 64'(yield_hint), 64'(m_yield));
        if (e_issue) chk(issue_word == word_data, "R9 issue_word", issue_word, word_data);
        if (issue_en && n_iss < 16) begin
            iss_t[n_iss] = cyc;
            n_iss++;
        end
        acc = 1'b0;
        if (word_valid && m_slot == 0) begin
            m_ctl  = word_data;
            m_slot = 1;
            acc    = 1'b1;
        end
        m_pend = (m_pend & ~bar_release);
        if (e_issue) begin
            m_pend  = m_pend | onehot6(f[7:5]) | onehot6(f[10:8]);
            m_slot  = (m_slot == 3) ? 0 : m_slot + 1;
            m_stall = int'(f[3:0]);
            acc     = 1'b1;
        end else if (m_stall != 0) begin
            m_stall--;
        end
        m_yield = e_issue && f[4];
        if (acc) rp++;
        cyc++;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        word_valid = 1'b0;
        word_data = '0;
        bar_release = '0;
        m_slot = 0; m_ctl = '0; m_stall = 0; m_pend = '0; m_yield = 1'b0;
        repeat (3) @(negedge clk);
        word_valid = 1'b1;
        word_data  = 64'hFFFF_FFFF_FFFF_FFFF;
        #5;
        chk(issue_en == 1'b0, "R1 reset issue_en", 64'(issue_en), 64'd0);
        chk(yield_hint == 1'b0, "R1 reset yield_hint", 64'(yield_hint), 64'd0);
        chk(word_ready == 1'b1, "R1 reset control phase", 64'(word_ready), 64'd1);
        @(negedge clk);
        word_valid = 1'b0;
        rst_n = 1'b1;
        #5;
        chk(issue_en == 1'b0 && yield_hint == 1'b0, "R1 after reset", 64'({issue_en, yield_hint}), 64'd0);

        // Directed group 0: stall 3 + yield + arm barrier 2; wait on 2; no-arm indices with reserved bits and bit 63
        wq[wn++] = {1'b1, mkf(0, 0, 7, 6, 6'd0, 4'hF), mkf(0, 0, 7, 7, 6'b000100, 4'h0),
                    mkf(3, 1, 2, 7, 6'd0, 4'h0)};
        wq[wn++] = 64'h1111_0000_0000_0001;
        wq[wn++] = 64'h2222_0000_0000_0002;
        wq[wn++] = 64'h3333_0000_0000_0003;
        // Directed group 1: wait on all barriers + stall 5; read barrier 3; wait on 3
        wq[wn++] = {1'b0, mkf(0, 0, 7, 7, 6'b001000, 4'h0), mkf(0, 0, 7, 3, 6'd0, 4'h0),
                    mkf(5, 0, 7, 7, 6'b111111, 4'h0)};
        wq[wn++] = 64'h4444_0000_0000_0004;
        wq[wn++] = 64'h5555_0000_0000_0005;
        wq[wn++] = 64'h6666_0000_0000_0006;
        for (int k = 0; k < 200 && (rp < wn || m_stall != 0); k++) step(1'b1, 1'b0);

        chk(n_iss == 6, "R2 directed issue count", 64'(n_iss), 64'd6);
        chk(iss_t[1] == iss_t[0] + 9, "R3 R5 R6 release of write barrier", 64'(iss_t[1] - iss_t[0]), 64'd9);
        chk(iss_t[2] == iss_t[1] + 1, "R4 zero stall back-to-back", 64'(iss_t[2] - iss_t[1]), 64'd1);
        chk(iss_t[3] == iss_t[2] + 2, "R6 R10 no-arm indices and reserved bits", 64'(iss_t[3] - iss_t[2]), 64'd2);
        chk(iss_t[4] == iss_t[3] + 6, "R3 R4 stall of five", 64'(iss_t[4] - iss_t[3]), 64'd6);
        chk(iss_t[5] == iss_t[4] + 5, "R6 read barrier wait", 64'(iss_t[5] - iss_t[4]), 64'd5);

        // Random groups
        for (int g = 0; g < 60; g++) begin
            wq[wn++] = {$urandom, $urandom};
            for (int i = 0; i < 3; i++) wq[wn++] = {$urandom, $urandom};
        end
        for (int k = 0; k < 20000 && rp < wn; k++) step(1'b0, 1'b1);
        chk(rp == wn, "R5 random stream drained", 64'(rp), 64'(wn));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule